// File: doc/BRIEF.md
# Buffer-Level Oscillator Trim Controller

This block steers the frequency of a pullable local sample clock so that a small elastic sample buffer, written at the rate of an incoming stream and read at the local rate, never fills up or runs dry. It works on counts, not edges. Over a window of timebase ticks it counts the samples entering and leaving the buffer. When the window closes it compares the net count and the current fill level with the half-full point. It then moves a signed trim code, with one LSB standing for 0.1 ppm, by a small amount. An external converter turns that code into the oscillator control voltage.

After reset, or when the input stream disappears or the buffer faults, the controller runs in an acquire state. This state uses a short window and allows multi-LSB steps. Once the rate difference has settled it changes to a tracking state. Tracking moves the code by at most one LSB per long window, which is 15 ticks by default, so one tick per second gives 15 seconds. Timing jitter on the incoming samples therefore never reaches the trim code. Sticky overflow and underflow flags report buffer faults. A status bit shows that the code is held at its clamp.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset, trim_code is 0 and locked, overflow_flag, underflow_flag and out_of_range are all 0.
- R2: trim_code and out_of_range change only on the clock edge that samples the tick that completes the current window. In tracking a window is max(cfg_track_ivl, TRACK_MIN_IVL = 15) ticks long. In acquire it is max(cfg_acq_ivl, 1) ticks long.
- R3: In tracking, with net = writes minus reads in the window, the code steps +1 if net > 0 and -1 if net < 0. If net = 0 it steps +1 when fill_level > DEPTH/2, -1 when fill_level < DEPTH/2, and holds when fill_level = DEPTH/2.
- R4: Only the number of strobes in a window matters. Their spacing and the width of each write pulse have no effect on the resulting code.
- R5: In acquire the step is net, saturated to ±ACQ_MAX_STEP (8). If net = 0 the step follows the fill rule of R3.
- R6: The code saturates at ±NARROW_LIM (1000) when wide_mode = 0 and at ±WIDE_LIM (3000) when wide_mode = 1. out_of_range is 1 after an update that saturated and 0 after one that did not.
- R7: In acquire, two consecutive windows with |net| <= LOCK_TOL (0) move the block to tracking and set locked to 1.
- R8: A write while fill_level = DEPTH sets overflow_flag. A read while fill_level = 0 sets underflow_flag. Both flags stay set until reset.
- R9: A buffer fault clears locked and returns the block to acquire.
- R10: A window with no writes leaves the code unchanged, clears locked and returns the block to acquire.
- R11: Each rising edge of wr_strobe_in counts as one write after a two-flop synchroniser. Each cycle with rd_strobe high counts as one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sample clock domain |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_strobe_in | input | 1 | Write strobe from the incoming stream domain, one rising edge per sample |
| rd_strobe | input | 1 | Read strobe in the local domain, one sample per high cycle |
| tick | input | 1 | Timebase tick, one cycle wide |
| fill_level | input | 7 | Buffer occupancy, 0 to DEPTH |
| wide_mode | input | 1 | 1 selects the wide trim clamp |
| cfg_track_ivl | input | 16 | Requested tracking window in ticks, raised to at least TRACK_MIN_IVL |
| cfg_acq_ivl | input | 16 | Acquire window in ticks, raised to at least 1 |
| trim_code | output | 16 | Signed oscillator trim, LSB = 0.1 ppm |
| locked | output | 1 | High while tracking |
| overflow_flag | output | 1 | Sticky: write seen with buffer full |
| underflow_flag | output | 1 | Sticky: read seen with buffer empty |
| out_of_range | output | 1 | Last update was saturated at the clamp |

## Verification
The internal state shows at the ports only when a window closes. A wrong window counter, acquire/track state or settle counter is therefore visible one cycle after the closing tick, as a wrong step size, a step at the wrong tick or a wrong locked level. For that reason the bench predicts the code after every window and also confirms that it stays frozen through the ticks before the closing one. A lost or doubled write in the synchroniser shows up as a net error of one at the next update. Faults are seen within a few cycles on the sticky flags and on the locked output.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
   typedef enum logic {
      ST_ACQ   = 1'b0,
      ST_TRACK = 1'b1
   } trim_state_e;
endpackage

// File: rtl/trim_edge_sync.sv
// Multi-flop synchroniser followed by a rising-edge detector.
module trim_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   initial begin
      assert (STAGES >= 2) else $error("trim_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/trim_window.sv
// Tick-based window timer with saturating event counters.
module trim_window #(
   parameter int CW = 12,
   parameter int IW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ev,
   input  logic          rd_ev,
   input  logic          tick,
   input  logic [IW-1:0] ivl,
   output logic          update,
   output logic [CW-1:0] wr_cnt,
   output logic [CW-1:0] rd_cnt
);
   logic [IW-1:0]      tick_q;
   logic [1:0]         ev;
   logic [1:0][CW-1:0] cnt_q;

   assign ev     = {rd_ev, wr_ev};
   assign update = tick && (tick_q >= ivl - IW'(1));
   assign wr_cnt = cnt_q[0];
   assign rd_cnt = cnt_q[1];

   always_ff @(posedge clk) begin
      if (!rst_n)      tick_q <= '0;
      else if (update) tick_q <= '0;
      else if (tick)   tick_q <= tick_q + IW'(1);
   end

   for (genvar g = 0; g < 2; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q[g] <= '0;
         else if (update)
            cnt_q[g] <= {{(CW-1){1'b0}}, ev[g]};
         else if (ev[g] && (cnt_q[g] != {CW{1'b1}}))
            cnt_q[g] <= cnt_q[g] + CW'(1);
      end
   end
endmodule

// File: rtl/trim_step.sv
// Combinational step decision and clamp for one window result.
module trim_step
   import osc_trim_pkg::*;
#(
   parameter int CW         = 12,
   parameter int TW         = 16,
   parameter int FW         = 7,
   parameter int DEPTH      = 64,
   parameter int ACQ_MAX    = 8,
   parameter int NARROW_LIM = 1000,
   parameter int WIDE_LIM   = 3000,
   parameter int LOCK_TOL   = 0
) (
   input  trim_state_e     state,
   input  logic [CW-1:0]   wr_cnt,
   input  logic [CW-1:0]   rd_cnt,
   input  logic [FW-1:0]   fill,
   input  logic            wide,
   input  logic signed [TW-1:0] trim_q,
   output logic signed [TW-1:0] trim_d,
   output logic            sat,
   output logic            rate_ok,
   output logic            no_input
);
   localparam int HALF = DEPTH / 2;

   int net_i, dir_i, step_i, sum_i, lim_i;

   always_comb begin
      net_i    = int'(wr_cnt) - int'(rd_cnt);
      no_input = (wr_cnt == '0);
      dir_i    = (int'(fill) > HALF) ? 1 : ((int'(fill) < HALF) ? -1 : 0);
      if (no_input)
         step_i = 0;
      else if (net_i == 0)
         step_i = dir_i;
      else if (state == ST_TRACK)
         step_i = (net_i > 0) ? 1 : -1;
      else if (net_i > ACQ_MAX)
         step_i = ACQ_MAX;
      else if (net_i < -ACQ_MAX)
         step_i = -ACQ_MAX;
      else
         step_i = net_i;
      lim_i   = wide ? WIDE_LIM : NARROW_LIM;
      sum_i   = int'(trim_q) + step_i;
      sat     = 1'b0;
      if (sum_i > lim_i) begin
         sum_i = lim_i;
         sat   = 1'b1;
      end else if (sum_i < -lim_i) begin
         sum_i = -lim_i;
         sat   = 1'b1;
      end
      trim_d  = TW'(sum_i);
      rate_ok = (net_i <= LOCK_TOL) && (net_i >= -LOCK_TOL);
   end
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
   import osc_trim_pkg::*;
#(
   parameter int DEPTH         = 64,
   parameter int TW            = 16,
   parameter int CW            = 12,
   parameter int IW            = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int TRACK_MIN_IVL = 15,
   parameter int ACQ_MAX_STEP  = 8,
   parameter int NARROW_LIM    = 1000,
   parameter int WIDE_LIM      = 3000,
   parameter int LOCK_TOL      = 0,
   localparam int FW           = $clog2(DEPTH) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_strobe_in,
   input  logic                 rd_strobe,
   input  logic                 tick,
   input  logic [FW-1:0]        fill_level,
   input  logic                 wide_mode,
   input  logic [IW-1:0]        cfg_track_ivl,
   input  logic [IW-1:0]        cfg_acq_ivl,
   output logic signed [TW-1:0] trim_code,
   output logic                 locked,
   output logic                 overflow_flag,
   output logic                 underflow_flag,
   output logic                 out_of_range
);
   initial begin
      assert (DEPTH >= 4) else $error("osc_trim_ctrl: DEPTH too small");
      assert (NARROW_LIM < WIDE_LIM) else $error("osc_trim_ctrl: wide clamp must exceed narrow clamp");
      assert (WIDE_LIM < (1 << (TW-1))) else $error("osc_trim_ctrl: TW too narrow for WIDE_LIM");
      assert (TRACK_MIN_IVL >= 1 && TRACK_MIN_IVL < (1 << IW)) else $error("osc_trim_ctrl: bad TRACK_MIN_IVL");
      assert (ACQ_MAX_STEP >= 1) else $error("osc_trim_ctrl: ACQ_MAX_STEP must be positive");
   end

   trim_state_e          state_q;
   logic                 settle_q;
   logic                 wr_ev, update, fault_full, fault_empty;
   logic [IW-1:0]        ivl_eff;
   logic [CW-1:0]        wr_cnt, rd_cnt;
   logic signed [TW-1:0] trim_d;
   logic                 sat, rate_ok, no_input;

   trim_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(wr_strobe_in), .pulse(wr_ev)
   );

   always_comb begin
      if (state_q == ST_TRACK)
         ivl_eff = (cfg_track_ivl < IW'(TRACK_MIN_IVL)) ? IW'(TRACK_MIN_IVL) : cfg_track_ivl;
      else
         ivl_eff = (cfg_acq_ivl == '0) ? IW'(1) : cfg_acq_ivl;
   end

   trim_window #(.CW(CW), .IW(IW)) u_win (
      .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .rd_ev(rd_strobe), .tick(tick),
      .ivl(ivl_eff), .update(update), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt)
   );

   trim_step #(
      .CW(CW), .TW(TW), .FW(FW), .DEPTH(DEPTH), .ACQ_MAX(ACQ_MAX_STEP),
      .NARROW_LIM(NARROW_LIM), .WIDE_LIM(WIDE_LIM), .LOCK_TOL(LOCK_TOL)
   ) u_step (
      .state(state_q), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .fill(fill_level),
      .wide(wide_mode), .trim_q(trim_code), .trim_d(trim_d), .sat(sat),
      .rate_ok(rate_ok), .no_input(no_input)
   );

   assign fault_full  = wr_ev && (fill_level == FW'(DEPTH));
   assign fault_empty = rd_strobe && (fill_level == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q        <= ST_ACQ;
         settle_q       <= 1'b0;
         trim_code      <= '0;
         locked         <= 1'b0;
         overflow_flag  <= 1'b0;
         underflow_flag <= 1'b0;
         out_of_range   <= 1'b0;
      end else begin
         if (update) begin
            trim_code    <= trim_d;
            out_of_range <= sat;
            if (no_input) begin
               state_q  <= ST_ACQ;
               locked   <= 1'b0;
               settle_q <= 1'b0;
            end else if (state_q == ST_ACQ) begin
               if (!rate_ok) begin
                  settle_q <= 1'b0;
               end else if (settle_q) begin
                  state_q  <= ST_TRACK;
                  locked   <= 1'b1;
                  settle_q <= 1'b0;
               end else begin
                  settle_q <= 1'b1;
               end
            end
         end
         if (fault_full)  overflow_flag  <= 1'b1;
         if (fault_empty) underflow_flag <= 1'b1;
         if (fault_full || fault_empty) begin
            state_q  <= ST_ACQ;
            locked   <= 1'b0;
            settle_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/trim_ctrl_chk.sv
module trim_ctrl_chk #(
   parameter int TW       = 16,
   parameter int WIDE_LIM = 3000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick,
   input logic signed [TW-1:0] trim_code,
   input logic                 locked,
   input logic                 overflow_flag,
   input logic                 underflow_flag,
   input logic                 out_of_range
);
   assert_trim_only_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(trim_code));

   assert_oor_only_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(out_of_range));

   assert_track_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> ((int'(trim_code) - int'($past(trim_code)) <= 1) &&
                  (int'(trim_code) - int'($past(trim_code)) >= -1)));

   assert_trim_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(trim_code) <= WIDE_LIM) && (int'(trim_code) >= -WIDE_LIM));

   assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_flag |=> overflow_flag);

   assert_no_underflow_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_flag |=> underflow_flag);

   assert_fault_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(overflow_flag) || $rose(underflow_flag)) |-> !locked);
endmodule

bind osc_trim_ctrl trim_ctrl_chk #(.TW(TW), .WIDE_LIM(WIDE_LIM)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .trim_code(trim_code), .locked(locked),
   .overflow_flag(overflow_flag), .underflow_flag(underflow_flag),
   .out_of_range(out_of_range)
);

// File: tb/osc_trim_ctrl_tb_top.sv
`timescale 1ns/1ps
module osc_trim_ctrl_tb_top;
   localparam int DEPTH = 64;
   localparam int HALF  = DEPTH / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_s = 1'b0, rd_s = 1'b0, tick = 1'b0, wide = 1'b0;
   logic [6:0] fill = 7'd32;
   logic [15:0] cfg_trk = 16'd0, cfg_acq = 16'd2;
   logic signed [15:0] trim;
   logic locked, ovf, udf, oor;

   int checks = 0, errors = 0;
   // bench-side expectation
   int m_trim = 0, m_good = 0;
   bit m_track = 0, m_oor = 0;

   always #2.5 clk = ~clk;

   osc_trim_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_strobe_in(wr_s), .rd_strobe(rd_s), .tick(tick),
      .fill_level(fill), .wide_mode(wide), .cfg_track_ivl(cfg_trk), .cfg_acq_ivl(cfg_acq),
      .trim_code(trim), .locked(locked), .overflow_flag(ovf), .underflow_flag(udf),
      .out_of_range(oor)
   );

   task automatic step_clk();
      @(posedge clk); #1;
   endtask

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int win_len();
      if (m_track) return (cfg_trk < 15) ? 15 : int'(cfg_trk);
      return (cfg_acq == 0) ? 1 : int'(cfg_acq);
   endfunction

   task automatic expect_update(int nw, int nr, int f);
      int net, dir, st, lim, sum;
      net = nw - nr;
      dir = (f > HALF) ? 1 : ((f < HALF) ? -1 : 0);
      if (nw == 0) st = 0;
      else if (net == 0) st = dir;
      else if (m_track) st = (net > 0) ? 1 : -1;
      else st = (net > 8) ? 8 : ((net < -8) ? -8 : net);
      lim = wide ? 3000 : 1000;
      sum = m_trim + st;
      m_oor = 0;
      if (sum > lim) begin sum = lim; m_oor = 1; end
      if (sum < -lim) begin sum = -lim; m_oor = 1; end
      m_trim = sum;
      if (nw == 0) begin m_track = 0; m_good = 0; end
      else if (!m_track) begin
         if (net != 0) m_good = 0;
         else if (m_good == 1) begin m_track = 1; m_good = 0; end
         else m_good = 1;
      end
   endtask

   task automatic tick_once();
      tick = 1'b1; step_clk(); tick = 1'b0; step_clk();
   endtask

   // one full window: nw writes, nr reads at random spacing, then the ticks
   task automatic window(string tag, int nw, int nr, int f);
      int wi = 0, ri = 0, len, prev;
      fill = 7'(f);
      while (wi < nw || ri < nr) begin
         if (wi < nw && (ri >= nr || $urandom_range(0, 1) == 0)) begin
            wr_s = 1'b1; repeat ($urandom_range(1, 3)) step_clk();
            wr_s = 1'b0; repeat ($urandom_range(1, 3)) step_clk();
            wi++;
         end else begin
            rd_s = 1'b1; step_clk(); rd_s = 1'b0;
            repeat ($urandom_range(0, 2)) step_clk();
            ri++;
         end
      end
      repeat (6) step_clk();
      len  = win_len();
      prev = int'(trim);
      repeat (len - 1) tick_once();
      check({tag, " R2 frozen before closing tick"}, int'(trim), prev);
      tick_once();
      expect_update(nw, nr, f);
      check({tag, " trim"}, int'(trim), m_trim);
      check({tag, " locked"}, int'(locked), int'(m_track));
      check({tag, " out_of_range"}, int'(oor), int'(m_oor));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) step_clk();
      check("R1 trim", int'(trim), 0);
      check("R1 locked", int'(locked), 0);
      check("R1 flags", int'({ovf, udf, oor}), 0);
      rst_n = 1'b1;
      step_clk();

      // acquire steps, R5 and R11 (write pulses of random width)
      window("R5 net+5", 5, 0, 40);
      window("R5 saturate +12", 12, 0, 40);
      window("R5 net-3", 3, 6, 40);
      window("R5 fill rule", 4, 4, 50);
      window("R7 second settle", 2, 2, HALF);
      check("R7 locked after two settled windows", int'(locked), 1);

      // tracking with random counts and spacing, R3 R4
      for (int i = 0; i < 16; i++)
         window("R3 R4 random track", $urandom_range(1, 6), $urandom_range(0, 6),
                $urandom_range(1, DEPTH - 1));
      window("R3 hold at half", 3, 3, HALF);
      window("R3 net beats fill", 2, 4, 60);

      // longer programmed tracking window, R2
      cfg_trk = 16'd17;
      window("R2 ivl17", 4, 2, 20);
      window("R2 ivl17b", 1, 3, 20);
      cfg_trk = 16'd0;

      // loss of input, R10
      window("R10 no writes", 0, 3, 50);
      check("R10 unlocked", int'(locked), 0);

      // drive to the positive clamp in acquire, R6
      for (int i = 0; i < 140 && !m_oor; i++) window("R6 climb", 8, 0, 40);
      check("R6 clamped at +1000", int'(trim), 1000);
      wide = 1'b1;
      window("R6 wide clamp releases", 8, 0, 40);
      wide = 1'b0;
      window("R6 narrow reclamp", 8, 0, 40);
      m_oor = 0;
      for (int i = 0; i < 300 && !m_oor; i++) window("R6 descend", 1, 9, 40);
      check("R6 clamped at -1000", int'(trim), -1000);

      // relock then faults, R8 R9
      window("R7 relock a", 3, 3, HALF);
      window("R7 relock b", 3, 3, HALF);
      check("R7 relocked", int'(locked), 1);
      check("R8 no overflow yet", int'(ovf), 0);
      fill = 7'(DEPTH);
      wr_s = 1'b1; repeat (2) step_clk(); wr_s = 1'b0; repeat (3) step_clk();
      check("R8 overflow set", int'(ovf), 1);
      check("R9 overflow unlocks", int'(locked), 0);
      check("R8 underflow still clear", int'(udf), 0);
      fill = 7'd0;
      rd_s = 1'b1; step_clk(); rd_s = 1'b0; step_clk();
      check("R8 underflow set", int'(udf), 1);
      fill = 7'd30;
      repeat (5) step_clk();
      check("R8 overflow sticky", int'(ovf), 1);
      check("R8 underflow sticky", int'(udf), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule